// File: doc/BRIEF.md
# Undervoltage and Thermal Fault Manager

This block gathers the digital outputs of a set of undervoltage comparators and two temperature comparators. From them it produces one fault indication, an enable for each supervised output and a global off request. Each monitor input passes through its own falling-edge persistence filter. A monitor is considered only after the soft-start sequencer has armed it. Two parameter masks give each monitor its character. The first mask says whether the output uses an on-chip pass element, so that an undervoltage latches that regulator off. If not, the undervoltage only raises the fault. The second mask says whether an undervoltage during initial start-up must shut the whole block down.

A central state machine has four states. ST_RUN is normal operation. ST_SHUTDOWN is entered while the shutdown request is held. ST_STARTUP_OFF is the start-up latch-off. ST_THERMAL_OFF is the over-temperature shutdown. The transitions are:
- RUN to THERMAL_OFF on the critical temperature flag.
- RUN to STARTUP_OFF on a filtered start-up-class undervoltage before the second soft-start ramp has completed.
- RUN to SHUTDOWN on the shutdown request.
- SHUTDOWN to THERMAL_OFF on the critical temperature flag.
- SHUTDOWN back to RUN when the request is released.

The two off states are left only by the active-low bias power-on reset.

Top module: `uvt_fault_mgr`

## Requirements
- R1: While and after `por_n` is low, `fault_out` is 0, `all_off` is 0 and every `reg_en` bit is 1.
- R2: A monitor counts as an undervoltage only once its `uv_raw` bit has been sampled high on FILT_TICKS consecutive rising clock edges while armed. A shorter high pulse has no effect. `fault_out` rises right after the FILT_TICKS-th such edge.
- R3: A monitor whose `armed` bit is 0 is ignored, and its filter stays cleared.
- R4: For a monitor whose INT_MASK bit is 0 (external pass element), the undervoltage sets `fault_out` only while it persists. `fault_out` clears one edge after `uv_raw` drops, and no `reg_en` bit changes.
- R5: For a monitor whose INT_MASK bit is 1 (internal pass element), the undervoltage sets `fault_out` and drives `reg_en` bit i (bit index = monitor index) to 0. Both hold after `uv_raw` clears, until a shutdown request or POR.
- R6: A filtered undervoltage on a monitor whose STARTUP_MASK bit is 1, before `ramp2_done` has been seen high since POR, sets `all_off` and `fault_out` and clears all `reg_en`. This latch-off survives shutdown requests and is cleared only by POR. Once `ramp2_done` has been seen, the rule no longer applies until the next POR.
- R7: While `temp_warn` is 1 (and no shutdown request), `fault_out` is 1 and no output is turned off.
- R8: One edge after `temp_crit` is sampled high, `all_off` and `fault_out` are 1. They stay so until POR, even across shutdown requests.
- R9: While `ss_req` is 1, `all_off` is 1, every `reg_en` bit is 0 and `fault_out` is 0. The request clears every internal-element latch.
- R10: For every monitor whose INT_MASK bit is 0, its `reg_en` bit always equals the inverse of `all_off`.

Default masks: INT_MASK = 5'b01001 (monitors 0 and 3 internal), STARTUP_MASK = 5'b00011 (monitors 0 and 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Bias power-on reset, active low, asynchronous |
| uv_raw | input | N_MON | Comparator outputs, 1 = below falling threshold |
| armed | input | N_MON | Monitor armed by soft-start sequencer |
| ramp2_done | input | 1 | Second soft-start ramp finished |
| temp_warn | input | 1 | Temperature at fault level |
| temp_crit | input | 1 | Temperature at shutdown level |
| ss_req | input | 1 | Shutdown request (soft-start pin held low) |
| fault_out | output | 1 | Combined fault indication |
| all_off | output | 1 | Turn every output off |
| reg_en | output | N_MON | Per-output enable |

## Verification
The assertions check the following on every cycle:
- the shutdown request keeps the fault low and forces everything off;
- a critical temperature is followed by shutdown with the fault set;
- an off state that is not caused by the request persists;
- enables of external-element outputs only mirror the global off.

Only the bench scenarios can show the rest:
- the exact filter length and the point where a short pulse is forgotten;
- the masking of unarmed monitors;
- the latched per-regulator shutdown and how the request releases it;
- the difference between an undervoltage before and after the second ramp.

// File: rtl/uvt_fault_pkg.sv
package uvt_fault_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_SHUTDOWN,
        ST_STARTUP_OFF,
        ST_THERMAL_OFF
    } mgr_state_e;
endpackage

// File: rtl/uvt_uv_filter.sv
module uvt_uv_filter #(
    parameter int FILT_TICKS = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic enable,
    input  logic uv_raw,
    output logic uv_event
);
    localparam int CW = $clog2(FILT_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_TICKS);

    logic [CW-1:0] cnt_q;

    // saturating run-length counter of consecutive low-voltage samples
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (!enable || !uv_raw) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign uv_event = (cnt_q == LIMIT);
endmodule

// File: rtl/uvt_latch_bank.sv
module uvt_latch_bank #(
    parameter int                N_MON    = 5,
    parameter logic [N_MON-1:0]  INT_MASK = 5'b01001
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic [N_MON-1:0] uv_event,
    output logic [N_MON-1:0] latched
);
    for (genvar i = 0; i < N_MON; i++) begin : g_bit
        if (INT_MASK[i]) begin : g_int
            logic hold_q;
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    hold_q <= 1'b0;
                end else if (clr) begin
                    hold_q <= 1'b0;
                end else if (uv_event[i]) begin
                    hold_q <= 1'b1;
                end
            end
            assign latched[i] = hold_q;
        end else begin : g_ext
            assign latched[i] = 1'b0;
        end
    end
endmodule

// File: rtl/uvt_fault_mgr.sv
module uvt_fault_mgr
    import uvt_fault_pkg::*;
#(
    parameter int               N_MON        = 5,
    parameter int               FILT_TICKS   = 1000,
    parameter logic [N_MON-1:0] INT_MASK     = 5'b01001,
    parameter logic [N_MON-1:0] STARTUP_MASK = 5'b00011
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [N_MON-1:0] uv_raw,
    input  logic [N_MON-1:0] armed,
    input  logic             ramp2_done,
    input  logic             temp_warn,
    input  logic             temp_crit,
    input  logic             ss_req,
    output logic             fault_out,
    output logic             all_off,
    output logic [N_MON-1:0] reg_en
);
    mgr_state_e       state_q, state_d;
    logic             startup_over_q;
    logic [N_MON-1:0] uv_evt;
    logic [N_MON-1:0] int_latched;
    logic             running;
    logic             startup_hit;
    logic             terminal;

    assign running = (state_q == ST_RUN) && !ss_req;

    for (genvar i = 0; i < N_MON; i++) begin : g_mon
        uvt_uv_filter #(.FILT_TICKS(FILT_TICKS)) filt_i (
            .clk      (clk),
            .por_n    (por_n),
            .enable   (armed[i] && running),
            .uv_raw   (uv_raw[i]),
            .uv_event (uv_evt[i])
        );
    end

    uvt_latch_bank #(.N_MON(N_MON), .INT_MASK(INT_MASK)) latch_i (
        .clk      (clk),
        .por_n    (por_n),
        .clr      (ss_req),
        .uv_event (uv_evt),
        .latched  (int_latched)
    );

    // sticky record that the second ramp finished since the last POR
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            startup_over_q <= 1'b0;
        end else if (ramp2_done) begin
            startup_over_q <= 1'b1;
        end
    end

    assign startup_hit = (|(uv_evt & STARTUP_MASK)) && !startup_over_q;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (temp_crit)        state_d = ST_THERMAL_OFF;
                else if (startup_hit) state_d = ST_STARTUP_OFF;
                else if (ss_req)      state_d = ST_SHUTDOWN;
            end
            ST_SHUTDOWN: begin
                if (temp_crit)        state_d = ST_THERMAL_OFF;
                else if (!ss_req)     state_d = ST_RUN;
            end
            ST_STARTUP_OFF: state_d = ST_STARTUP_OFF;
            ST_THERMAL_OFF: state_d = ST_THERMAL_OFF;
        endcase
    end

    // outputs
    always_comb begin
        terminal  = (state_q == ST_STARTUP_OFF) || (state_q == ST_THERMAL_OFF);
        all_off   = ss_req || terminal;
        fault_out = !ss_req &&
                    (terminal || temp_warn || (|uv_evt) || (|int_latched));
        for (int i = 0; i < N_MON; i++) begin
            reg_en[i] = !all_off &&
                        !(INT_MASK[i] && (int_latched[i] || uv_evt[i]));
        end
    end
endmodule

// File: rtl/uvt_fault_mgr_chk.sv
module uvt_fault_mgr_chk #(
    parameter int               N_MON    = 5,
    parameter logic [N_MON-1:0] INT_MASK = 5'b01001
) (
    input logic             clk,
    input logic             por_n,
    input logic             ss_req,
    input logic             temp_crit,
    input logic             fault_out,
    input logic             all_off,
    input logic [N_MON-1:0] reg_en
);
    assert_ss_quiet_R9: assert property (@(posedge clk) disable iff (!por_n)
        ss_req |-> (!fault_out && all_off && reg_en == '0));

    assert_hot_off_R8: assert property (@(posedge clk) disable iff (!por_n)
        temp_crit |=> all_off);

    assert_hot_fault_R8: assert property (@(posedge clk) disable iff (!por_n)
        temp_crit |=> (fault_out || ss_req));

    assert_terminal_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
        (all_off && !ss_req) |=> all_off);

    for (genvar i = 0; i < N_MON; i++) begin : g_ext
        if (!INT_MASK[i]) begin : g_chk
            assert_ext_en_R10: assert property (@(posedge clk) disable iff (!por_n)
                reg_en[i] == !all_off);
        end
    end
endmodule

bind uvt_fault_mgr uvt_fault_mgr_chk #(.N_MON(N_MON), .INT_MASK(INT_MASK)) chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .ss_req    (ss_req),
    .temp_crit (temp_crit),
    .fault_out (fault_out),
    .all_off   (all_off),
    .reg_en    (reg_en)
);

// File: tb/uvt_fault_mgr_tb_top.sv
module uvt_fault_mgr_tb_top;
    localparam int N = 5;
    localparam int F = 16;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic [N-1:0] uv_raw = '0;
    logic [N-1:0] armed = '0;
    logic         ramp2_done = 1'b0;
    logic         temp_warn = 1'b0;
    logic         temp_crit = 1'b0;
    logic         ss_req = 1'b0;
    logic         fault_out;
    logic         all_off;
    logic [N-1:0] reg_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string        rq;
        logic         f;
        logic         off;
        logic [N-1:0] en;
    } exp_t;

    exp_t sb_q[$];
    event sample_ev;

    always #5 clk = ~clk;

    uvt_fault_mgr #(.N_MON(N), .FILT_TICKS(F)) dut_i (
        .clk(clk), .por_n(por_n), .uv_raw(uv_raw), .armed(armed),
        .ramp2_done(ramp2_done), .temp_warn(temp_warn), .temp_crit(temp_crit),
        .ss_req(ss_req), .fault_out(fault_out), .all_off(all_off), .reg_en(reg_en)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string rq, input logic f, input logic off,
                              input logic [N-1:0] en);
        exp_t e;
        e.rq = rq; e.f = f; e.off = off; e.en = en;
        sb_q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (fault_out !== e.f || all_off !== e.off || reg_en !== e.en) begin
                    n_bad++;
                    $display("FAIL %s: fault=%b off=%b en=%b, expected fault=%b off=%b en=%b",
                             e.rq, fault_out, all_off, reg_en, e.f, e.off, e.en);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #2;
        expect_out("R1 in reset", 1'b0, 1'b0, 5'b11111);
        cyc(2);
        por_n = 1'b1;
        cyc(2);
        expect_out("R1 after reset", 1'b0, 1'b0, 5'b11111);

        // startup phase over, everything armed
        ramp2_done = 1'b1;
        armed = 5'b11111;
        cyc(2);

        // R2: short pulse forgotten, full length counts
        uv_raw[2] = 1'b1;
        cyc(F - 1);
        expect_out("R2 pulse one short", 1'b0, 1'b0, 5'b11111);
        uv_raw[2] = 1'b0;
        cyc(3);
        uv_raw[2] = 1'b1;
        cyc(F);
        expect_out("R4 external uv flags only", 1'b1, 1'b0, 5'b11111);
        uv_raw[2] = 1'b0;
        cyc(1);
        expect_out("R4 external uv clears", 1'b0, 1'b0, 5'b11111);

        // R3: unarmed monitor ignored
        armed[4] = 1'b0;
        uv_raw[4] = 1'b1;
        cyc(3 * F);
        expect_out("R3 unarmed ignored", 1'b0, 1'b0, 5'b11111);
        armed[4] = 1'b1;
        cyc(F - 1);
        expect_out("R2 armed count not yet full", 1'b0, 1'b0, 5'b11111);
        cyc(1);
        expect_out("R2 armed count full", 1'b1, 1'b0, 5'b11111);
        uv_raw[4] = 1'b0;
        cyc(1);

        // R5: internal element latches its regulator off
        uv_raw[0] = 1'b1;
        cyc(F);
        expect_out("R5 internal uv", 1'b1, 1'b0, 5'b11110);
        uv_raw[0] = 1'b0;
        cyc(2);
        expect_out("R5 internal latch holds", 1'b1, 1'b0, 5'b11110);

        // R9: shutdown request
        ss_req = 1'b1;
        temp_warn = 1'b1;
        cyc(1);
        expect_out("R9 shutdown forces off, fault low", 1'b0, 1'b1, 5'b00000);
        ss_req = 1'b0;
        temp_warn = 1'b0;
        cyc(2);
        expect_out("R9 latch cleared after release", 1'b0, 1'b0, 5'b11111);

        // R7: temperature warning
        temp_warn = 1'b1;
        cyc(1);
        expect_out("R7 warn sets fault only", 1'b1, 1'b0, 5'b11111);
        temp_warn = 1'b0;
        cyc(1);
        expect_out("R7 warn clears", 1'b0, 1'b0, 5'b11111);

        // R6: startup-class uv after second ramp only flags
        uv_raw[1] = 1'b1;
        cyc(F + 2);
        expect_out("R6 after ramp2 no latch-off", 1'b1, 1'b0, 5'b11111);
        uv_raw[1] = 1'b0;
        cyc(1);
        expect_out("R6 after ramp2 clears", 1'b0, 1'b0, 5'b11111);

        // R8: critical temperature
        temp_crit = 1'b1;
        cyc(1);
        expect_out("R8 crit shuts all", 1'b1, 1'b1, 5'b00000);
        temp_crit = 1'b0;
        cyc(3);
        expect_out("R8 crit persists", 1'b1, 1'b1, 5'b00000);
        ss_req = 1'b1;
        cyc(1);
        expect_out("R9 request during thermal off", 1'b0, 1'b1, 5'b00000);
        ss_req = 1'b0;
        cyc(3);
        expect_out("R8 survives shutdown request", 1'b1, 1'b1, 5'b00000);

        // POR clears thermal off
        por_n = 1'b0;
        ramp2_done = 1'b0;
        cyc(1);
        por_n = 1'b1;
        cyc(2);
        expect_out("R1 POR clears thermal off", 1'b0, 1'b0, 5'b11111);

        // R6: startup latch-off
        uv_raw[0] = 1'b1;
        cyc(F + 2);
        expect_out("R6 startup latch-off", 1'b1, 1'b1, 5'b00000);
        uv_raw[0] = 1'b0;
        ss_req = 1'b1;
        cyc(2);
        ss_req = 1'b0;
        cyc(2);
        expect_out("R6 latch-off survives request", 1'b1, 1'b1, 5'b00000);

        // internal monitor outside startup mask during startup
        por_n = 1'b0;
        cyc(1);
        por_n = 1'b1;
        cyc(2);
        uv_raw[3] = 1'b1;
        cyc(F + 2);
        expect_out("R5 non-startup internal during startup", 1'b1, 1'b0, 5'b10111);
        uv_raw[3] = 1'b0;
        cyc(2);
        expect_out("R5 hold during startup", 1'b1, 1'b0, 5'b10111);

        #1;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule